// File: doc/BRIEF.md
# Multiplexed Host-Bus Access Sequencer

This block turns single requests from an internal requester into accesses on a 16-bit multiplexed external bus with one chip select. Each access puts the address on the shared lines under an address-latch strobe for one bus clock. It then drives write data under a write strobe, or releases the lines under a read strobe. It can hold the access in a stall phase until an external ready line, a FIFO-full flag or a FIFO-empty flag allows it to go on. It then reports completion with a single-cycle done pulse. Read data is captured on the bus-clock rising edge that ends the data phase.

The bus clock runs at half the system clock. It can be forced low, gated so that it runs only during an access, or inverted. The strobe polarities and the stall sources come from a 12-bit configuration word that is loaded with `cfg_load`. One bit of that word is a self-clearing command. It turns the next accepted request into a write of `cre_value_i` to the memory's configuration register. During that access `cre_o` is driven high.

Top module: `hbus_seq`

## Requirements
- R1: After reset the configuration word is 0x200, so the address-latch strobe is active high and the read and write strobes are active low. `ale_o`=0, `rd_o`=1, `wr_o`=1, `ad_oe`=0, `done_o`=0 and `cre_pend_o`=0.
- R2: `req_ready` is high in idle only on the system cycle before a bus-clock rise. An accepted request spends one bus period (2 cycles) in the address phase and at least one bus period in the data phase. `done_o` is then high for exactly one cycle, 6 cycles after acceptance when there is no stall. At most one of the latch, read and write strobes is active at a time.
- R3: During the address phase `ad_o` carries `req_addr` with `ad_oe`=1. During a write strobe `ad_o` carries the write data with `ad_oe`=1. During a read strobe `ad_oe`=0.
- R4: Configuration bit 7 sets the write-strobe polarity, bit 8 the read-strobe polarity and bit 9 the latch-strobe polarity (1 = active high, 0 = active low).
- R5: With bit 3 set, the access stalls while the synchronized `rdy_i` is low. With bit 4 also set, it stalls while `rdy_i` is high instead. Both the read and write strobes stay active through the stall.
- R6: With bit 5 set, writes stall while `full_i` is high. With bit 6 set, reads stall while `empty_i` is high. A flag has no effect on the other direction.
- R7: Stall inputs pass through two flops. Let r be the number of cycles between acceptance and the release of a stall input. The data phase then ends on the first odd cycle count p ≥ max(5, r+3), and `done_o` appears at p+1.
- R8: With bit 0 set, `bus_clk_o` is held low.
- R9: With bit 1 set, `bus_clk_o` runs only while an access is in progress. This applies only when clock output (bit 11) is 1 and `div_zero_i` is 0; otherwise bit 1 has no effect.
- R10: With bit 2 set, the running bus clock is inverted. In idle on a `req_ready` cycle, `bus_clk_o` equals bit 2.
- R11: Loading bit 10 as 1 sets `cre_pend_o`. The next accepted request becomes a write of `cre_value_i`, whatever its direction or data. `cre_o` is high for the whole access, and `cre_pend_o` clears when its done pulse ends. Loading bit 10 as 0 does not clear it.
- R12: `rdata_o` takes `ad_i` when a read's data phase ends. A write leaves `rdata_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Last captured read data |
| cfg_load | input | 1 | Load configuration word |
| cfg_word | input | 12 | Configuration word |
| cre_value_i | input | 16 | Value for the configuration-register write |
| div_zero_i | input | 1 | Clock divider count is zero |
| cre_pend_o | output | 1 | Configuration write pending |
| bus_clk_o | output | 1 | Bus clock |
| ale_o | output | 1 | Address-latch strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| cre_o | output | 1 | Configuration-register enable |
| ad_o | output | 16 | Multiplexed address/data out |
| ad_oe | output | 1 | Output enable for ad_o |
| ad_i | input | 16 | Multiplexed data in |
| rdy_i | input | 1 | External ready |
| full_i | input | 1 | External FIFO full |
| empty_i | input | 1 | External FIFO empty |

## Verification
A stall release and the read-data capture can fall on the same bus-clock edge. The bench provokes this by releasing a stall input two cycles after acceptance. The synchronized release then arrives exactly at the first data-phase evaluation, so the access must finish with no stall period, with done at cycle 6 and `rdata_o` equal to `ad_i`. One cycle later, r = 3 must add exactly one bus period. Both cases are swept over every stall source, both directions and both ready polarities, and are judged against p ≥ max(5, r+3) computed in the bench.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_ADDR, PH_DATA, PH_STALL, PH_DONE} phase_t;

  localparam int CFG_W       = 12;
  localparam int B_CLK_GATE  = 0;
  localparam int B_IDLE_GATE = 1;
  localparam int B_CLK_INV   = 2;
  localparam int B_RDY_EN    = 3;
  localparam int B_RDY_INV   = 4;
  localparam int B_FULL_EN   = 5;
  localparam int B_EMPTY_EN  = 6;
  localparam int B_WR_HIGH   = 7;
  localparam int B_RD_HIGH   = 8;
  localparam int B_ALE_HIGH  = 9;
  localparam int B_CRE_GO    = 10;
  localparam int B_CLK_OUT   = 11;
  localparam logic [CFG_W-1:0] CFG_RESET = 12'h200;

  // Pin level for a strobe of the given polarity.
  function automatic logic pin_level(input logic active, input logic high);
    return high ? active : ~active;
  endfunction

  // True when any enabled stall source holds the access.
  function automatic logic stall_eval(input logic rdy_en, input logic rdy_inv,
                                      input logic rdy, input logic full_en,
                                      input logic full, input logic empty_en,
                                      input logic empty, input logic is_wr);
    logic not_ready;
    not_ready = rdy_en & (rdy_inv ? rdy : ~rdy);
    return not_ready | (full_en & is_wr & full) | (empty_en & ~is_wr & empty);
  endfunction
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hbus_clkgen.sv
module hbus_clkgen (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic gate,
  input  logic idle_gate,
  input  logic inv,
  input  logic out_en,
  input  logic div_zero,
  output logic step,
  output logic bus_clk
);
  logic bclk;
  logic idle_ok;
  logic held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk <= 1'b0;
    else        bclk <= ~bclk;
  end

  // step marks the system cycle whose closing edge raises the bus clock
  assign step    = ~bclk;
  assign idle_ok = idle_gate & out_en & ~div_zero;
  assign held    = gate | (idle_ok & ~busy);
  assign bus_clk = held ? 1'b0 : (bclk ^ inv);
endmodule

// File: rtl/hbus_seq.sv
module hbus_seq
  import hbus_pkg::*;
#(
  parameter int BUS_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0] req_wdata,
  output logic             done_o,
  output logic [BUS_W-1:0] rdata_o,
  input  logic             cfg_load,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [BUS_W-1:0] cre_value_i,
  input  logic             div_zero_i,
  output logic             cre_pend_o,
  output logic             bus_clk_o,
  output logic             ale_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic             cre_o,
  output logic [BUS_W-1:0] ad_o,
  output logic             ad_oe,
  input  logic [BUS_W-1:0] ad_i,
  input  logic             rdy_i,
  input  logic             full_i,
  input  logic             empty_i
);
  localparam int NSTALL = 3;

  phase_t           state;
  logic [CFG_W-1:0] cfg_q;
  logic [BUS_W-1:0] lat_addr, lat_data;
  logic             lat_wr, lat_cre;
  logic [NSTALL-1:0] stall_sync;

  // named internal events
  logic step, accept, finish, stall_now, busy, in_data, cre_next;
  logic ale_act, rd_act, wr_act, gate_on;

  hbus_sync #(.W(NSTALL), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({empty_i, full_i, rdy_i}), .q(stall_sync)
  );

  assign busy    = (state != PH_IDLE);
  assign gate_on = cfg_q[B_CLK_GATE];

  hbus_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .gate(gate_on),
    .idle_gate(cfg_q[B_IDLE_GATE]), .inv(cfg_q[B_CLK_INV]),
    .out_en(cfg_q[B_CLK_OUT]), .div_zero(div_zero_i),
    .step(step), .bus_clk(bus_clk_o)
  );

  assign in_data   = (state == PH_DATA) || (state == PH_STALL);
  assign req_ready = (state == PH_IDLE) && step;
  assign accept    = req_valid && req_ready;
  assign finish    = (state == PH_DONE) && step;
  assign stall_now = stall_eval(cfg_q[B_RDY_EN], cfg_q[B_RDY_INV], stall_sync[0],
                                cfg_q[B_FULL_EN], stall_sync[1],
                                cfg_q[B_EMPTY_EN], stall_sync[2], lat_wr);
  assign cre_next  = (cfg_q[B_CRE_GO] & ~(finish & lat_cre))
                   | (cfg_load & cfg_word[B_CRE_GO]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PH_IDLE;
      cfg_q    <= CFG_RESET;
      lat_addr <= '0;
      lat_data <= '0;
      lat_wr   <= 1'b0;
      lat_cre  <= 1'b0;
      rdata_o  <= '0;
    end else begin
      if (cfg_load) cfg_q <= cfg_word;
      cfg_q[B_CRE_GO] <= cre_next;
      if (accept) begin
        state    <= PH_ADDR;
        lat_addr <= req_addr;
        lat_data <= cfg_q[B_CRE_GO] ? cre_value_i : req_wdata;
        lat_wr   <= req_write | cfg_q[B_CRE_GO];
        lat_cre  <= cfg_q[B_CRE_GO];
      end else if (step) begin
        case (state)
          PH_ADDR: state <= PH_DATA;
          PH_DATA, PH_STALL: begin
            if (stall_now) begin
              state <= PH_STALL;
            end else begin
              state <= PH_DONE;
              if (!lat_wr) rdata_o <= ad_i;
            end
          end
          PH_DONE: state <= PH_IDLE;
          default: state <= state;
        endcase
      end
    end
  end

  assign ale_act    = (state == PH_ADDR);
  assign rd_act     = in_data && !lat_wr;
  assign wr_act     = in_data && lat_wr;
  assign ale_o      = pin_level(ale_act, cfg_q[B_ALE_HIGH]);
  assign rd_o       = pin_level(rd_act, cfg_q[B_RD_HIGH]);
  assign wr_o       = pin_level(wr_act, cfg_q[B_WR_HIGH]);
  assign ad_o       = ale_act ? lat_addr : lat_data;
  assign ad_oe      = ale_act || wr_act;
  assign cre_o      = lat_cre && busy;
  assign done_o     = finish;
  assign cre_pend_o = cfg_q[B_CRE_GO];
endmodule

// File: rtl/hbus_seq_chk.sv
module hbus_seq_chk
  import hbus_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done_o,
  input logic             ale_act,
  input logic             rd_act,
  input logic             wr_act,
  input logic             gate_on,
  input logic             bus_clk_o,
  input logic             cre_pend_o,
  input logic             ad_oe,
  input phase_t           state,
  input logic             stall_now,
  input logic [BUS_W-1:0] rdata_o
);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ale_act, rd_act, wr_act}));

  assert_read_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act |-> !ad_oe);

  assert_stall_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == PH_STALL) |-> $past(stall_now));

  assert_gate_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on |-> !bus_clk_o);

  assert_cre_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cre_pend_o) |-> $past(done_o));

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_IDLE) |=> $stable(rdata_o));
endmodule

bind hbus_seq hbus_seq_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done_o(done_o), .ale_act(ale_act),
  .rd_act(rd_act), .wr_act(wr_act), .gate_on(gate_on), .bus_clk_o(bus_clk_o),
  .cre_pend_o(cre_pend_o), .ad_oe(ad_oe), .state(state),
  .stall_now(stall_now), .rdata_o(rdata_o)
);

// File: tb/sim_hbus_seq.sv
module sim_hbus_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, cfg_load = 0, div_zero = 0;
  logic [15:0] req_addr = 0, req_wdata = 0, cre_val = 16'hC3A5, ad_i = 0;
  logic [11:0] cfg_word = 12'h200, cur_cfg = 12'h200;
  logic rdy_i = 1, full_i = 0, empty_i = 0;
  logic req_ready, done_o, cre_pend_o, bus_clk_o, ale_o, rd_o, wr_o, cre_o, ad_oe;
  logic [15:0] rdata_o, ad_o;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  hbus_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done_o(done_o), .rdata_o(rdata_o), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .cre_value_i(cre_val), .div_zero_i(div_zero), .cre_pend_o(cre_pend_o),
    .bus_clk_o(bus_clk_o), .ale_o(ale_o), .rd_o(rd_o), .wr_o(wr_o), .cre_o(cre_o),
    .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .rdy_i(rdy_i), .full_i(full_i),
    .empty_i(empty_i)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected pin level: equal to polarity when active
  function automatic logic lvl(input bit active, input logic high);
    return active ~^ high;
  endfunction

  task automatic load_cfg(input logic [11:0] w);
    @(negedge clk);
    cfg_word = w;
    cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
    cur_cfg = w;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_access(input logic wr, input logic [15:0] addr, input logic [15:0] wdata,
                           input logic [15:0] rdval, input int kind, input int rel,
                           input bit cre_exp, input string tag);
    logic wr_eff;
    logic [15:0] dexp, rd_before;
    bit stalls, idle_ok, busy, held;
    int p, m, bad_lvl, bad_ad, bad_clk, bad_cre, done_n, done_cnt;
    bad_lvl = 0; bad_ad = 0; bad_clk = 0; bad_cre = 0; done_n = -1; done_cnt = 0;
    wr_eff = wr | cre_exp;
    dexp = cre_exp ? cre_val : wdata;
    stalls = (kind == 1 && cur_cfg[3]) || (kind == 2 && cur_cfg[5] && wr_eff)
          || (kind == 3 && cur_cfg[6] && !wr_eff);
    if (stalls) begin
      m = (rel + 3 > 5) ? rel + 3 : 5;
      p = (m % 2 == 1) ? m : m + 1;
    end else p = 5;
    idle_ok = cur_cfg[1] && cur_cfg[11] && !div_zero;
    if (kind == 1) rdy_i = cur_cfg[4];
    if (kind == 2) full_i = 1;
    if (kind == 3) empty_i = 1;
    ad_i = rdval;
    repeat (4) @(negedge clk);
    rd_before = rdata_o;
    req_write = wr; req_addr = addr; req_wdata = wdata; req_valid = 1;
    while (!req_ready) @(negedge clk);
    for (int n = 1; n <= p + 3; n++) begin
      @(negedge clk);
      if (n == 1) req_valid = 0;
      if (n == rel) begin
        if (kind == 1) rdy_i = ~cur_cfg[4];
        full_i = 0; empty_i = 0;
      end
      if (ale_o !== lvl(n <= 2, cur_cfg[9])) bad_lvl++;
      if (rd_o !== lvl(n >= 3 && n < p && !wr_eff, cur_cfg[8])) bad_lvl++;
      if (wr_o !== lvl(n >= 3 && n < p && wr_eff, cur_cfg[7])) bad_lvl++;
      if (n <= 2 && (ad_o !== addr || ad_oe !== 1)) bad_ad++;
      if (n >= 3 && n < p && wr_eff && (ad_o !== dexp || ad_oe !== 1)) bad_ad++;
      if (n >= 3 && n < p && !wr_eff && ad_oe !== 0) bad_ad++;
      if (cre_o !== (cre_exp && n <= p + 1)) bad_cre++;
      busy = (n <= p + 1);
      held = cur_cfg[0] || (idle_ok && !busy);
      if (bus_clk_o !== (held ? 1'b0 : ((n % 2 == 1) ^ cur_cfg[2]))) bad_clk++;
      if (done_o) begin
        done_cnt++;
        if (done_n < 0) done_n = n;
      end
    end
    rdy_i = 1; full_i = 0; empty_i = 0;
    check(bad_lvl == 0, "R4", {tag, " strobe levels"}, bad_lvl, 0);
    check(bad_ad == 0, "R3", {tag, " ad bus"}, bad_ad, 0);
    check(done_n == p + 1 && done_cnt == 1, "R7", {tag, " done cycle (R2 R5 R6)"},
          done_n, p + 1);
    check(bad_clk == 0, "R10", {tag, " bus clock during access (R9)"}, bad_clk, 0);
    check(bad_cre == 0, "R11", {tag, " cre_o"}, bad_cre, 0);
    check(rdata_o === (wr_eff ? rd_before : rdval), "R12", {tag, " rdata"},
          rdata_o, wr_eff ? rd_before : rdval);
  endtask

  task automatic clk_watch(input int cycles, output int highs);
    highs = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (bus_clk_o) highs++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int highs;
    logic [11:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(ale_o === 0 && rd_o === 1 && wr_o === 1, "R1", "idle strobe levels",
          {ale_o, rd_o, wr_o}, 3'b011);
    check(ad_oe === 0 && done_o === 0 && cre_pend_o === 0, "R1", "idle flags",
          {ad_oe, done_o, cre_pend_o}, 0);
    do_access(1, 16'h1234, 16'hBEEF, 16'h0, 0, 0, 0, "R1 default wr");
    // R4 polarity sweep
    for (int pol = 0; pol < 8; pol++) begin
      load_cfg(12'(pol << 7));
      for (int wr = 0; wr < 2; wr++)
        do_access(wr[0], 16'(16'hA000 + pol), 16'(16'h5A00 + wr), 16'(16'h7700 + pol),
                  0, 0, 0, "R4 polarity");
    end
    // R5 R6 R7 stall sweep
    for (int kind = 1; kind <= 3; kind++)
      for (int inv = 0; inv < 2; inv++)
        for (int en = 0; en < 2; en++)
          for (int wr = 0; wr < 2; wr++)
            for (int ri = 0; ri < 3; ri++) begin
              if (kind != 1 && inv == 1) continue;
              w = 12'h200;
              if (kind == 1) begin w[3] = en[0]; w[4] = inv[0]; end
              if (kind == 2) w[5] = en[0];
              if (kind == 3) w[6] = en[0];
              load_cfg(w);
              do_access(wr[0], 16'h0C00, 16'h3C3C, 16'(16'h9000 + ri * 16 + kind),
                        kind, (ri == 0) ? 2 : (ri == 1) ? 3 : 9, 0,
                        kind == 1 ? "R5 ready stall" : "R6 flag stall");
            end
    // R8 clock gate
    load_cfg(12'h201);
    clk_watch(20, highs);
    check(highs == 0, "R8", "gated clock highs", highs, 0);
    // R9 idle gating and its enables
    load_cfg(12'hA02);
    div_zero = 0;
    clk_watch(20, highs);
    check(highs == 0, "R9", "idle-gated clock highs", highs, 0);
    do_access(0, 16'h0042, 16'h0, 16'h4242, 0, 0, 0, "R9 gated access");
    div_zero = 1;
    clk_watch(20, highs);
    check(highs == 10, "R9", "divider zero ignores idle gate", highs, 10);
    div_zero = 0;
    load_cfg(12'h202);
    clk_watch(20, highs);
    check(highs == 10, "R9", "clock output off ignores idle gate", highs, 10);
    // R10 inversion
    load_cfg(12'h204);
    @(negedge clk);
    if (!req_ready) @(negedge clk);
    check(bus_clk_o === 1, "R10", "inverted clock at ready cycle", bus_clk_o, 1);
    do_access(1, 16'h0404, 16'h1111, 16'h0, 0, 0, 0, "R10 inverted access");
    load_cfg(12'h200);
    @(negedge clk);
    if (!req_ready) @(negedge clk);
    check(bus_clk_o === 0 && req_ready === 1, "R2", "plain clock low at ready", bus_clk_o, 0);
    // R11 configuration write
    load_cfg(12'h600);
    check(cre_pend_o === 1, "R11", "pending after set", cre_pend_o, 1);
    load_cfg(12'h200);
    check(cre_pend_o === 1, "R11", "writing zero keeps pending", cre_pend_o, 1);
    do_access(0, 16'h00C0, 16'h0, 16'hDEAD, 0, 0, 1, "R11 cre access");
    check(cre_pend_o === 0, "R11", "self clear", cre_pend_o, 0);
    do_access(0, 16'h00C1, 16'h0, 16'hFACE, 0, 0, 0, "R11 following read");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule